// File: doc/BRIEF.md
# Channel-side programmed I/O command sequencer

This block is the channel end of one programmed I/O transfer on a parallel device channel. A host-side request names the direction, a command byte, a device address and, for a write, a data word. The block places these on the outbound buses together with an address-valid flag. It then runs a fully interlocked handshake with whichever device recognises the address. First it waits a deskew interval and raises the address gate. It then waits for the device's gate return, captures the condition code (and the read word on a read), pulses the data strobe, drops the gate and waits for gate return to fall. Only after that does it release the buses and report completion.

A device that never answers is timed out. The gate is withdrawn before the buses are released, the strobe is never raised, and the transfer completes with condition code 0, meaning no device attached. The deskew, timeout and strobe lengths are parameters counted in clock cycles. For example, a 100 MHz clock suits 20 cycles of deskew (200 ns) and a 400-cycle timeout (4 µs, above the 3 µs a device may take). The request side is a single-cycle start and a single-cycle done pulse with the results held until the next start.

Top module: `chan_io_seq`

## Requirements
- R1: While reset is held and after its release without a start, busy_o, done_o, gate_o, strobe_o, tmo_o, cc_o, rdata_o, abus_o and dbus_o are all zero.
- R2: A start accepted in idle drives abus_o, from the next cycle, with the command in bits 7:0, the device address in bits 15:8 and bit 16 set. On a write it drives dbus_o with the write word, and on a read it drives zero. Both buses then hold these values unchanged until the transfer completes.
- R3: gate_o rises exactly DESKEW_CYC cycles after the buses become valid.
- R4: When gate_ret_i is sampled high while the gate waits, the cycle-aligned cc_i value is captured into cc_o. On a read rdata_i is captured into rdata_o, and on a write rdata_o is zero. strobe_o is then high for exactly STROBE_CYC cycles, starting the next cycle, with gate_o high throughout.
- R5: gate_o and strobe_o fall together at the end of the strobe. The buses return to zero, busy_o falls and done_o pulses for one cycle, all in the cycle after gate_ret_i is first sampled low.
- R6: If gate_ret_i is not sampled high during the TMO_CYC cycles that gate_o is up, gate_o falls and strobe_o never rises. cc_o reads 0, tmo_o reads 1 and rdata_o reads 0. One cycle after the gate falls, the buses return to zero and done_o pulses.
- R7: A gate return sampled in the last cycle of the timeout window is treated as a normal response, not a timeout.
- R8: start_i asserted while busy_o is high has no effect on the buses, the handshake or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a transfer (taken only in idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| cmd_i | input | 8 | Command byte |
| dev_i | input | 8 | Device address |
| wdata_i | input | 16 | Write data word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 3 | Condition code of the last transfer |
| tmo_o | output | 1 | Last transfer timed out |
| rdata_o | output | 16 | Read word of the last transfer |
| abus_o | output | 17 | Outbound command/address bus, bit 16 = valid |
| dbus_o | output | 16 | Outbound write data bus |
| gate_o | output | 1 | Address gate |
| gate_ret_i | input | 1 | Gate return from the device |
| cc_i | input | 3 | Condition code from the device |
| rdata_i | input | 16 | Read data from the device |
| strobe_o | output | 1 | Data strobe |

## Verification
The gate-return response and the timeout expiry can land in the same cycle. This happens when the device answers on the last sampled cycle of the window. The bench provokes it with a device model whose latency equals the timeout length, and then with one cycle more. It expects a normal strobe and captured condition code in the first case and an abort with code 0 in the second. Random latencies and release holds around these edges, plus start pulses thrown in during busy, are compared cycle by cycle against expected gate, strobe, bus and done timing computed from the parameters.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESKEW,
      ST_WAIT,
      ST_STROBE,
      ST_RELEASE,
      ST_ABORT
   } seq_state_t;
endpackage

// File: rtl/chan_seq_timer.sv
module chan_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) cnt_o <= '0;
      else                 cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl
   import chan_seq_pkg::*;
#(
   parameter int DESKEW_CYC = 20,
   parameter int TMO_CYC    = 400,
   parameter int STROBE_CYC = 4,
   parameter int CNT_W      = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ret_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             clr_o,
   output logic             load_o,
   output logic             capture_o,
   output logic             abort_o,
   output logic             release_o,
   output logic             gate_o,
   output logic             strobe_o,
   output logic             done_o,
   output logic             busy_o
);
   localparam logic [CNT_W-1:0] DSK_LAST = CNT_W'(DESKEW_CYC - 1);
   localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);
   localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CYC - 1);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_DESKEW;
         ST_DESKEW:  if (cnt_i == DSK_LAST) state_d = ST_WAIT;
         ST_WAIT: begin
            if (ret_i)                  state_d = ST_STROBE;
            else if (cnt_i == TMO_LAST) state_d = ST_ABORT;
         end
         ST_STROBE:  if (cnt_i == STB_LAST) state_d = ST_RELEASE;
         ST_RELEASE: if (!ret_i) state_d = ST_IDLE;
         ST_ABORT:   state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   assign clr_o     = (state_d != state_q) || (state_q == ST_IDLE);
   assign load_o    = (state_q == ST_IDLE) && start_i;
   assign capture_o = (state_q == ST_WAIT) && ret_i;
   assign abort_o   = (state_q == ST_WAIT) && (state_d == ST_ABORT);
   assign release_o = ((state_q == ST_RELEASE) || (state_q == ST_ABORT)) && (state_d == ST_IDLE);
   assign busy_o    = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         gate_o   <= 1'b0;
         strobe_o <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= release_o;
         gate_o  <= (state_d == ST_WAIT) || (state_d == ST_STROBE);
         strobe_o <= (state_d == ST_STROBE);
      end
   end

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) && start_i |=> (state_q != ST_DESKEW) || ($past(state_q) == ST_DESKEW)); // R8
   AST_ABORT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ABORT) |-> !strobe_o && !$past(strobe_o)); // R6
   AST_DONE_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !gate_o && !strobe_o); // R5
endmodule

// File: rtl/chan_seq_capture.sv
module chan_seq_capture #(
   parameter int CMD_W    = 8,
   parameter int DEV_W    = 8,
   parameter int DATA_W   = 16,
   parameter int CC_W     = 3,
   parameter bit HAS_READ = 1'b1,
   localparam int ABUS_W  = CMD_W + DEV_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              capture_i,
   input  logic              abort_i,
   input  logic              release_i,
   input  logic              wr_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [DEV_W-1:0]  dev_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CC_W-1:0]   cc_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ABUS_W-1:0] abus_o,
   output logic [DATA_W-1:0] dbus_o,
   output logic [CC_W-1:0]   cc_o,
   output logic              tmo_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abus_o <= '0;
         dbus_o <= '0;
         wr_q   <= 1'b0;
         cc_o   <= '0;
         tmo_o  <= 1'b0;
      end else begin
         if (load_i) begin
            abus_o <= {1'b1, dev_i, cmd_i};
            dbus_o <= wr_i ? wdata_i : '0;
            wr_q   <= wr_i;
         end else if (release_i) begin
            abus_o <= '0;
            dbus_o <= '0;
         end
         if (capture_i) begin
            cc_o  <= cc_i;
            tmo_o <= 1'b0;
         end else if (abort_i) begin
            cc_o  <= '0;
            tmo_o <= 1'b1;
         end
      end
   end

   generate
      if (HAS_READ) begin : g_read
         always_ff @(posedge clk) begin
            if (!rst_n)         rdata_o <= '0;
            else if (capture_i) rdata_o <= wr_q ? '0 : rdata_i;
            else if (abort_i)   rdata_o <= '0;
         end
      end else begin : g_noread
         assign rdata_o = '0;
      end
   endgenerate

   AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !release_i |=> $stable(abus_o) && $stable(dbus_o)); // R2
   AST_TMO_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |-> cc_o == '0); // R6
endmodule

// File: rtl/chan_io_seq.sv
module chan_io_seq #(
   parameter int CMD_W      = 8,
   parameter int DEV_W      = 8,
   parameter int DATA_W     = 16,
   parameter int CC_W       = 3,
   parameter int DESKEW_CYC = 20,
   parameter int TMO_CYC    = 400,
   parameter int STROBE_CYC = 4,
   parameter bit HAS_READ   = 1'b1,
   localparam int ABUS_W    = CMD_W + DEV_W + 1,
   localparam int MAX_A     = (TMO_CYC > DESKEW_CYC) ? TMO_CYC : DESKEW_CYC,
   localparam int MAX_CYC   = (MAX_A > STROBE_CYC) ? MAX_A : STROBE_CYC,
   localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [DEV_W-1:0]  dev_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [CC_W-1:0]   cc_o,
   output logic              tmo_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ABUS_W-1:0] abus_o,
   output logic [DATA_W-1:0] dbus_o,
   output logic              gate_o,
   input  logic              gate_ret_i,
   input  logic [CC_W-1:0]   cc_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              strobe_o
);
   generate
      if (DESKEW_CYC < 1) begin : g_bad_dsk
         $error("DESKEW_CYC must be at least 1");
      end
      if (TMO_CYC < 1) begin : g_bad_tmo
         $error("TMO_CYC must be at least 1");
      end
      if (STROBE_CYC < 1) begin : g_bad_stb
         $error("STROBE_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic clr, load, capture, abort, release_b;

   chan_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .cnt_o(cnt)
   );

   chan_seq_ctrl #(
      .DESKEW_CYC(DESKEW_CYC), .TMO_CYC(TMO_CYC),
      .STROBE_CYC(STROBE_CYC), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ret_i(gate_ret_i),
      .cnt_i(cnt), .clr_o(clr), .load_o(load), .capture_o(capture),
      .abort_o(abort), .release_o(release_b), .gate_o(gate_o),
      .strobe_o(strobe_o), .done_o(done_o), .busy_o(busy_o)
   );

   chan_seq_capture #(
      .CMD_W(CMD_W), .DEV_W(DEV_W), .DATA_W(DATA_W),
      .CC_W(CC_W), .HAS_READ(HAS_READ)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .load_i(load), .capture_i(capture),
      .abort_i(abort), .release_i(release_b), .wr_i(wr_i),
      .cmd_i(cmd_i), .dev_i(dev_i), .wdata_i(wdata_i),
      .cc_i(cc_i), .rdata_i(rdata_i), .abus_o(abus_o), .dbus_o(dbus_o),
      .cc_o(cc_o), .tmo_o(tmo_o), .rdata_o(rdata_o)
   );

   AST_GATE_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o |-> abus_o[ABUS_W-1]); // R3
   AST_GATE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $past(abus_o[ABUS_W-1])); // R3
   AST_STROBE_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> gate_o); // R4
   AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (abus_o == '0) && (dbus_o == '0) && !busy_o); // R5
   AST_TMO_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_o) |-> !gate_o && !strobe_o); // R6
endmodule

// File: tb/chan_io_seq_bench.sv
module chan_io_seq_bench;
   localparam int CLK_NS = 10;
   localparam int D = 5;
   localparam int T = 20;
   localparam int S = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, wr_i = 1'b0;
   logic [7:0] cmd_i = '0, dev_i = '0;
   logic [15:0] wdata_i = '0;
   logic busy_o, done_o, tmo_o, gate_o, strobe_o;
   logic [2:0] cc_o;
   logic [15:0] rdata_o, dbus_o;
   logic [16:0] abus_o;
   logic gate_ret_i = 1'b0;
   logic [2:0] cc_i = '0;
   logic [15:0] rdata_i = '0;

   int checks = 0, errors = 0;
   int dev_lat = 1, dev_hold = 0, gcnt = 0, hcnt = 0;
   logic [2:0] dev_cc = '0;
   logic [15:0] dev_rd = '0;

   always #(CLK_NS/2) clk = ~clk;

   chan_io_seq #(.DESKEW_CYC(D), .TMO_CYC(T), .STROBE_CYC(S)) u_chan_io_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
      .cmd_i(cmd_i), .dev_i(dev_i), .wdata_i(wdata_i), .busy_o(busy_o),
      .done_o(done_o), .cc_o(cc_o), .tmo_o(tmo_o), .rdata_o(rdata_o),
      .abus_o(abus_o), .dbus_o(dbus_o), .gate_o(gate_o),
      .gate_ret_i(gate_ret_i), .cc_i(cc_i), .rdata_i(rdata_i),
      .strobe_o(strobe_o)
   );

   // device model: answers dev_lat negedges after seeing the gate, holds return dev_hold extra
   always @(negedge clk) begin
      if (gate_o) begin
         gcnt++;
         hcnt = 0;
         if (gcnt >= dev_lat) gate_ret_i = 1'b1;
      end else begin
         gcnt = 0;
         if (gate_ret_i) begin
            if (hcnt >= dev_hold) gate_ret_i = 1'b0;
            else hcnt++;
         end
      end
      cc_i    = gate_ret_i ? dev_cc : ~dev_cc;
      rdata_i = gate_ret_i ? dev_rd : ~dev_rd;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_gate(int k, bit timed, int j);
      return (k >= D) && (timed ? (k < D + T) : (k < D + j + S));
   endfunction

   function automatic bit exp_strobe(int k, bit timed, int j);
      return !timed && (k >= D + j) && (k < D + j + S);
   endfunction

   task automatic txn(input bit wr, input logic [7:0] cmd, input logic [7:0] dev,
                      input logic [15:0] wd, input int lat, input int hold,
                      input logic [2:0] cc, input logic [15:0] rd, input bit noise);
      bit timed;
      int done_k;
      logic [16:0] ab;
      logic [15:0] db;
      timed = (lat > T);
      done_k = timed ? (D + T + 1) : (D + lat + S + 1 + hold);
      ab = {1'b1, dev, cmd};
      db = wr ? wd : 16'h0;
      @(negedge clk);
      dev_lat = lat; dev_hold = hold; dev_cc = cc; dev_rd = rd;
      wr_i = wr; cmd_i = cmd; dev_i = dev; wdata_i = wd; start_i = 1'b1;
      for (int k = 0; k <= done_k; k++) begin
         @(negedge clk);
         if (k < done_k) begin
            chk(abus_o == ab, "R2 abus", abus_o, ab);
            chk(dbus_o == db, "R2 dbus", dbus_o, db);
            chk(busy_o == 1'b1, "R8 busy", busy_o, 1);
            chk(done_o == 1'b0, "R5 early done", done_o, 0);
         end
         chk(gate_o == exp_gate(k, timed, lat), timed ? "R6 gate" : "R3 gate", gate_o, exp_gate(k, timed, lat));
         chk(strobe_o == exp_strobe(k, timed, lat), "R4 strobe", strobe_o, exp_strobe(k, timed, lat));
         if (noise && (k + 1 < done_k)) begin
            start_i = ($urandom_range(0, 2) == 0);
            wr_i = ~wr; cmd_i = $urandom; dev_i = $urandom; wdata_i = $urandom;
         end else begin
            start_i = 1'b0;
         end
      end
      chk(done_o == 1'b1, "R5 done", done_o, 1);
      chk(abus_o == 17'h0 && dbus_o == 16'h0, "R5 release", {abus_o, dbus_o}, 0);
      chk(busy_o == 1'b0, "R5 busy", busy_o, 0);
      chk(tmo_o == timed, timed ? "R6 tmo" : "R7 tmo", tmo_o, timed);
      chk(cc_o == (timed ? 3'd0 : cc), timed ? "R6 cc" : "R4 cc", cc_o, timed ? 3'd0 : cc);
      chk(rdata_o == ((timed || wr) ? 16'h0 : rd), "R4 rdata", rdata_o, (timed || wr) ? 16'h0 : rd);
      @(negedge clk);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R8 idle after", {done_o, busy_o}, 0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk({busy_o, done_o, gate_o, strobe_o, tmo_o, cc_o} == '0, "R1 ctl in reset", {busy_o, done_o, gate_o, strobe_o, tmo_o, cc_o}, 0);
      chk(abus_o == '0 && dbus_o == '0 && rdata_o == '0, "R1 bus in reset", abus_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({busy_o, done_o, gate_o, strobe_o, tmo_o} == '0 && abus_o == '0, "R1 idle", {busy_o, gate_o}, 0);
      // directed corners
      txn(1'b1, 8'h3C, 8'hA5, 16'hBEEF, 1, 0, 3'd5, 16'h1234, 1'b0);
      txn(1'b0, 8'h01, 8'h7E, 16'hFFFF, 2, 0, 3'd2, 16'hC0DE, 1'b0);
      txn(1'b0, 8'h55, 8'h10, 16'h0, T, 0, 3'd7, 16'h9A9A, 1'b0);     // R7 last-cycle answer
      txn(1'b1, 8'h80, 8'h22, 16'h5A5A, T + 1, 0, 3'd6, 16'h1111, 1'b0); // R6 just missed
      txn(1'b0, 8'hFE, 8'h01, 16'h0, T + 3, 0, 3'd3, 16'h2222, 1'b1);   // R6 read abort
      txn(1'b1, 8'h0F, 8'hF0, 16'h0F0F, 4, 3, 3'd1, 16'h3333, 1'b1);    // R5 long hold
      txn(1'b0, 8'hAA, 8'h99, 16'h0, 3, 0, 3'd4, 16'h4444, 1'b1);       // R8 noise
      for (int n = 0; n < 40; n++) begin
         txn($urandom_range(0, 1), $urandom, $urandom, $urandom,
             $urandom_range(1, T + 3), $urandom_range(0, 3),
             $urandom_range(0, 7), $urandom, $urandom_range(0, 1));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=%0h expected=%0h", busy_o, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule